// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block is a synthesizable stand-in for a 512-byte serial EEPROM with an SPI slave port. It is used wherever a chip or an FPGA prototype needs a memory partner that behaves like a small SPI EEPROM. Examples are boot-loader tests, SPI master bring-up, or replacing a board-level part in emulation. The block runs on a fast system clock and oversamples the slave-side SPI pins. It assumes those pins are already synchronous to that clock.

Every access starts with a falling chip select, followed by one instruction byte. The block keeps a small status register. That register holds a busy flag, a write-enable latch and two protection bits. The block supports array reads with automatic address increment, page writes of up to one page of data, status reads and status writes. A page write or a status write starts a programming cycle of fixed length. A cycle counter models that programming time. During the cycle the buffered page is copied into the internal register array.

Top module: `eeprom_spi_model`

## Requirements
- R1: Instruction byte 0x06 sets the write-enable latch and 0x04 clears it, in both cases once all eight bits have arrived.
- R2: Instruction 0x05 returns the status byte on every following byte slot. The status byte has the busy flag in bit 0, the write-enable latch in bit 1, and protection bits P0 in bit 2 and P1 in bit 3. Bits 7..4 read as zero. After reset the status byte is 0x00 and every array byte is 0xFF.
- R3: A read instruction has the form 0000_A011, where A is address bit 8. It is followed by the low address byte. Each later byte slot returns the addressed byte MSB first and then advances the address, and 0x1FF advances to 0x000. Bytes the master shifts in during these slots have no effect.
- R4: A write instruction (0000_A010) and a status write (0x01) have no effect unless the write-enable latch is set when the instruction byte completes.
- R5: Data byte k of a write goes to the address whose upper five bits equal those of the start address and whose lower four bits are the start address plus k, modulo 16. A seventeenth byte therefore replaces the first one.
- R6: A write is committed only when chip select rises after at least one complete data byte, with no partial byte pending. Otherwise nothing is written and no programming cycle starts.
- R7: A committed write or status write sets the busy flag for PROG_CYCLES clock cycles. The write-enable latch is cleared when the busy flag falls.
- R8: While the busy flag is set, every instruction other than 0x05 is ignored. Its MISO output stays 0 and it changes no state.
- R9: A status write copies data bits 3..2 of its data byte into P1..P0 when it is committed, and leaves all other status bits untouched.
- R10: The protection bits choose which region is locked: P1P0=00 locks nothing, 01 locks 0x180-0x1FF, 10 locks 0x100-0x1FF, and 11 locks the whole array. A write whose page lies in a locked region does not start, and the write-enable latch stays set.
- R11: SPI modes (CPOL,CPHA) = (0,0) and (1,1) both work. MOSI is sampled on each rising SCK edge, and the next MISO bit is valid before the following rising edge.
- R12: MISO is 0 while chip select is high and during the instruction and address byte slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock from the master |
| mosi | input | 1 | Serial data from the master, MSB first |
| miso | output | 1 | Serial data to the master, MSB first |

## Verification
Every page of the array is written with a computed pattern, alternating between the two SPI modes. The whole array is then read back in a single burst that runs past 0x1FF. This catches a broken address increment, a lost page bit taken from the instruction byte, or a mode-dependent bit slip. Targeted sequences cover three more cases: a write that wraps inside its page, a write of 18 bytes, and a chip select that rises mid-byte. These expose a design that carries into the next page, one that drops the overwriting bytes, or one that commits a partial transfer. Other sequences issue a read and a latch clear during a programming cycle, and attempt writes to every protection setting. A design that served reads while busy, lost the latch early, or checked the wrong region would return wrong status bytes or a corrupted array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [2:0] OP_ARR_RD    = 3'b011;
    localparam logic [2:0] OP_ARR_WR    = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRD, ST_SRW, ST_SKIP
    } ctl_e;
endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       byte_vld,
    output logic [7:0] byte_val,
    output logic [2:0] bit_idx
);
    typedef struct packed {
        logic       sck;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       vld;
    } rx_s;

    rx_s q, d;

    always_comb begin
        d     = q;
        d.sck = sck;
        d.vld = 1'b0;
        if (cs_n) begin
            d.cnt = 3'd0;
        end else if (sck && !q.sck) begin
            d.sh  = {q.sh[6:0], mosi};
            d.cnt = q.cnt + 3'd1;
            d.vld = (q.cnt == 3'd7);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld = q.vld;
    assign byte_val = q.sh;
    assign bit_idx  = q.cnt;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CYCLES = 600
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic [$clog2(CYCLES+1)-1:0]   count
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_s;

    tm_s q, d;

    always_comb begin
        d    = q;
        done = q.busy && (q.cnt == CW'(CYCLES - 1));
        if (q.busy) begin
            if (done) d.busy = 1'b0;
            else      d.cnt  = q.cnt + 1'b1;
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy  = q.busy;
    assign count = q.cnt;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_spi_model.sv
module eeprom_spi_model
    import eeprom_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam int AW = 9;
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        ctl_e                           ctl;
        logic                           rd;
        logic                           cs;
        logic [AW-1:0]                  addr;
        logic [7:0]                     tx;
        logic                           wel;
        logic [1:0]                     bp;
        logic [1:0]                     bp_new;
        logic                           have;
        logic [PAGE_BYTES-1:0]          mask;
        logic [PAGE_BYTES-1:0][7:0]     pbuf;
    } st_s;

    st_s q, d;

    logic          byte_vld;
    logic [7:0]    byte_val;
    logic [2:0]    bit_idx;
    logic          start, busy, done;
    logic [CW-1:0] tcnt;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    wdata, rdata, status;
    logic          wip, wel;
    logic [1:0]    bp;

    function automatic logic locked(input logic [AW-1:0] a, input logic [1:0] p);
        case (p)
            2'b00:   return 1'b0;
            2'b01:   return a[AW-1] & a[AW-2];
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    spi_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .byte_vld(byte_vld), .byte_val(byte_val), .bit_idx(bit_idx)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .count(tcnt)
    );

    eeprom_array #(.AW(AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    assign status = {4'b0000, q.bp, q.wel, busy};
    assign raddr  = (q.ctl == ST_ADDR) ? {q.addr[AW-1], byte_val} : q.addr;
    assign we     = busy && (tcnt < CW'(PAGE_BYTES)) && q.mask[tcnt[PW-1:0]];
    assign waddr  = {q.addr[AW-1:PW], tcnt[PW-1:0]};
    assign wdata  = q.pbuf[tcnt[PW-1:0]];
    assign wip    = busy;
    assign wel    = q.wel;
    assign bp     = q.bp;
    assign miso   = cs_n ? 1'b0 : q.tx[3'd7 - bit_idx];

    always_comb begin
        d     = q;
        d.cs  = cs_n;
        start = 1'b0;
        if (cs_n) begin
            if (!q.cs && bit_idx == 3'd0 && q.have) begin
                if (q.ctl == ST_WDATA && !locked(q.addr, q.bp)) start = 1'b1;
                if (q.ctl == ST_SRW) begin
                    start = 1'b1;
                    d.bp  = q.bp_new;
                end
            end
            d.ctl = ST_IDLE;
            d.tx  = 8'h00;
        end else if (q.cs) begin
            d.ctl  = ST_OPC;
            d.tx   = 8'h00;
            d.have = 1'b0;
        end else if (byte_vld) begin
            case (q.ctl)
                ST_OPC: begin
                    if (busy && byte_val != OP_STAT_RD) begin
                        d.ctl = ST_SKIP;
                    end else if (byte_val == OP_STAT_RD) begin
                        d.ctl = ST_SRD;
                        d.tx  = status;
                    end else if (byte_val == OP_LATCH_SET) begin
                        d.wel = 1'b1;
                        d.ctl = ST_SKIP;
                    end else if (byte_val == OP_LATCH_CLR) begin
                        d.wel = 1'b0;
                        d.ctl = ST_SKIP;
                    end else if (byte_val == OP_STAT_WR) begin
                        d.ctl  = q.wel ? ST_SRW : ST_SKIP;
                        d.mask = '0;
                    end else if (byte_val[7:4] == 4'h0 && byte_val[2:0] == OP_ARR_RD) begin
                        d.ctl          = ST_ADDR;
                        d.rd           = 1'b1;
                        d.addr[AW-1]   = byte_val[3];
                    end else if (byte_val[7:4] == 4'h0 && byte_val[2:0] == OP_ARR_WR) begin
                        d.ctl          = q.wel ? ST_ADDR : ST_SKIP;
                        d.rd           = 1'b0;
                        d.addr[AW-1]   = byte_val[3];
                        d.mask         = '0;
                    end else begin
                        d.ctl = ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    if (q.rd) begin
                        d.tx   = rdata;
                        d.addr = {q.addr[AW-1], byte_val} + 1'b1;
                        d.ctl  = ST_RDATA;
                    end else begin
                        d.addr = {q.addr[AW-1], byte_val};
                        d.ctl  = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    d.tx   = rdata;
                    d.addr = q.addr + 1'b1;
                end
                ST_WDATA: begin
                    d.pbuf[q.addr[PW-1:0]] = byte_val;
                    d.mask[q.addr[PW-1:0]] = 1'b1;
                    d.addr[PW-1:0]         = q.addr[PW-1:0] + 1'b1;
                    d.have                 = 1'b1;
                end
                ST_SRD: d.tx = status;
                ST_SRW: begin
                    d.bp_new = byte_val[3:2];
                    d.have   = 1'b1;
                end
                default: ;
            endcase
        end
        if (done) d.wel = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/eeprom_spi_chk.sv
module eeprom_spi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wip,
    input logic       wel,
    input logic [1:0] bp
);
    a_r7_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    a_r4_cycle_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    a_r8_latch_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> $stable(wel));

    a_r6_start_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));

    a_r9_prot_moves_with_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $rose(wip));
endmodule

bind eeprom_spi_model eeprom_spi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wip(wip), .wel(wel), .bp(bp)
);

// File: tb/sim_eeprom_spi_model.sv
module sim_eeprom_spi_model;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;
    logic mode3 = 1'b0;
    logic fin = 1'b0;
    int   checks = 0;
    int   errors = 0;
    logic [7:0] ref_mem [512];
    logic [7:0] wbuf [32];

    always #5 clk = ~clk;

    eeprom_spi_model u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk);
        sck = mode3;
        nclk(2);
        cs_n = 1'b0;
        nclk(2);
    endtask

    task automatic desel();
        nclk(2);
        cs_n = 1'b1;
        nclk(4);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck  = 1'b0;
        mosi = b;
        nclk(4);
        r    = miso;
        sck  = 1'b1;
        nclk(4);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            xbit(tb[i], r);
            rb[i] = r;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, r);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel();
        xfer(8'h05, r);
        xfer(8'h00, s);
        desel();
    endtask

    task automatic stat_is(input string tag, input logic [7:0] exp);
        logic [7:0] s;
        rdsr(s);
        chk(tag, s, exp);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        s = 8'h01;
        for (int i = 0; i < 40 && s[0]; i++) rdsr(s);
        chk("R7 busy flag clears", s[0], 0);
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        sel();
        xfer(8'h01, r);
        xfer(v, r);
        desel();
    endtask

    task automatic write_bytes(input logic [8:0] a, input int n);
        logic [7:0] r;
        sel();
        xfer({4'h0, a[8], 3'b010}, r);
        xfer(a[7:0], r);
        for (int k = 0; k < n; k++) xfer(wbuf[k], r);
        desel();
    endtask

    task automatic ref_apply(input logic [8:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            logic [3:0] lo;
            lo = a[3:0] + 4'(k);
            ref_mem[{a[8:4], lo}] = wbuf[k];
        end
    endtask

    task automatic read_check(input logic [8:0] a, input int n, input logic zero, input string tag);
        logic [7:0] r;
        sel();
        xfer({4'h0, a[8], 3'b011}, r);
        chk("R12 miso low in instruction slot", r, 0);
        xfer(a[7:0], r);
        chk("R12 miso low in address slot", r, 0);
        for (int k = 0; k < n; k++) begin
            logic [8:0] ad;
            ad = a + 9'(k);
            xfer(8'(k * 13 + 7), r);
            chk(tag, r, zero ? 8'h00 : ref_mem[ad]);
        end
        desel();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        nclk(4);
        rst_n = 1'b1;
        nclk(4);

        chk("R12 miso low while deselected", miso, 0);
        stat_is("R2 reset status", 8'h00);
        read_check(9'h000, 4, 1'b0, "R2 reset array content");

        wbuf[0] = 8'h12; wbuf[1] = 8'h34;
        write_bytes(9'h010, 2);
        stat_is("R4 write without latch starts nothing", 8'h00);
        read_check(9'h010, 2, 1'b0, "R4 array untouched");

        cmd1(8'h06);
        stat_is("R1 latch set", 8'h02);
        cmd1(8'h04);
        stat_is("R1 latch cleared", 8'h00);

        for (int p = 0; p < 32; p++) begin
            mode3 = p[0];
            for (int k = 0; k < 16; k++) wbuf[k] = 8'(((p * 16 + k) * 37 + 11) ^ p);
            cmd1(8'h06);
            write_bytes(9'(p * 16), 16);
            ref_apply(9'(p * 16), 16);
            if (p < 2) stat_is("R7 busy with latch during cycle", 8'h03);
            wait_idle();
            if (p < 2) stat_is("R7 latch cleared after cycle", 8'h00);
        end
        mode3 = 1'b0;
        read_check(9'h000, 514, 1'b0, "R3 full sweep mode 0 with wrap");
        mode3 = 1'b1;
        read_check(9'h1F8, 12, 1'b0, "R11 read in mode 3 across wrap");
        mode3 = 1'b0;

        for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
        cmd1(8'h06);
        write_bytes(9'h00E, 4);
        ref_apply(9'h00E, 4);
        wait_idle();
        read_check(9'h000, 16, 1'b0, "R5 wrap inside page");

        for (int k = 0; k < 18; k++) wbuf[k] = 8'hC0 + 8'(k);
        cmd1(8'h06);
        write_bytes(9'h120, 18);
        ref_apply(9'h120, 18);
        wait_idle();
        read_check(9'h120, 16, 1'b0, "R5 seventeenth byte overwrites first");

        cmd1(8'h06);
        sel();
        xfer(8'h02, r);
        xfer(8'h40, r);
        xfer(8'h55, r);
        for (int i = 0; i < 3; i++) begin
            logic rb;
            xbit(1'b1, rb);
        end
        desel();
        stat_is("R6 partial byte commits nothing", 8'h02);
        write_bytes(9'h040, 0);
        stat_is("R6 no data byte commits nothing", 8'h02);
        read_check(9'h040, 1, 1'b0, "R6 array untouched");

        wbuf[0] = 8'h5A;
        write_bytes(9'h0A0, 1);
        ref_apply(9'h0A0, 1);
        cmd1(8'h04);
        read_check(9'h000, 1, 1'b1, "R8 read ignored while busy");
        stat_is("R8 latch clear ignored while busy", 8'h03);
        wait_idle();
        read_check(9'h0A0, 1, 1'b0, "R8 write landed after cycle");

        cmd1(8'h06);
        wrsr(8'hFF);
        stat_is("R9 status write sets both protection bits only", 8'h0F);
        wait_idle();
        stat_is("R9 status after cycle", 8'h0C);
        wrsr(8'h00);
        stat_is("R4 status write without latch ignored", 8'h0C);
        cmd1(8'h06);
        wbuf[0] = 8'h99;
        write_bytes(9'h000, 1);
        stat_is("R10 all locked, no start, latch kept", 8'h0E);
        wrsr(8'h04);
        wait_idle();
        stat_is("R9 protection 01", 8'h04);

        cmd1(8'h06);
        wbuf[0] = 8'h11;
        write_bytes(9'h100, 1);
        ref_apply(9'h100, 1);
        stat_is("R10 0x100 open under 01", 8'h07);
        wait_idle();
        cmd1(8'h06);
        wbuf[0] = 8'h22;
        write_bytes(9'h180, 1);
        stat_is("R10 0x180 locked under 01", 8'h06);
        wrsr(8'h08);
        wait_idle();
        stat_is("R9 protection 10", 8'h08);

        cmd1(8'h06);
        wbuf[0] = 8'h33;
        write_bytes(9'h0F0, 1);
        ref_apply(9'h0F0, 1);
        stat_is("R10 0x0F0 open under 10", 8'h0B);
        wait_idle();
        cmd1(8'h06);
        wbuf[0] = 8'h44;
        write_bytes(9'h1F0, 1);
        stat_is("R10 0x1F0 locked under 10", 8'h0A);
        wrsr(8'h00);
        wait_idle();
        stat_is("R9 protection cleared", 8'h00);
        read_check(9'h100, 1, 1'b0, "R10 0x100 content");
        read_check(9'h180, 1, 1'b0, "R10 0x180 content");
        read_check(9'h0F0, 1, 1'b0, "R10 0x0F0 content");
        read_check(9'h1F0, 1, 1'b0, "R10 0x1F0 content");
        read_check(9'h000, 1, 1'b0, "R10 0x000 content");

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule